// File: doc/BRIEF.md
# Passcode-Locked Interrupt Register Bank

This block is a small bank of 32-bit registers that collects hardware event pulses into sticky status bits and drives one level-sensitive interrupt line. A mask decides which pending status bits reach the interrupt. Software cannot write the mask directly. It clears mask bits by writing 1s to an enable register and sets them by writing 1s to a disable register. A set mask bit blocks its source.

All register writes are frozen until software writes a passcode to the lock register. Any other value written to the lock register freezes the bank again. Hardware events keep setting status bits whether the bank is locked or not.

The register port takes full words at word-aligned byte offsets. The offsets are:

| Offset | Register |
|--------|----------|
| 0x00 | lock |
| 0x04 | status |
| 0x08 | mask |
| 0x0C | enable |
| 0x10 | disable |

Reads are combinational from the addressed register. The implemented status bits are bit 31 and bits 14 down to 0, which is the mask 0x80007FFF.

Top module: `irq_lock_regbank`

## Requirements
- R1: After reset the lock register reads 1, status reads 0x00000000, mask reads 0x80007FFF, and irq_o is 0.
- R2: A write of exactly 0x0000DF0D to offset 0x00 makes the lock register read 0. A write of any other value to offset 0x00 makes it read 1. The lock register accepts writes at all times.
- R3: While the lock register reads 1, writes to any offset other than 0x00 change nothing.
- R4: At offset 0x04, writing 1 clears the matching implemented status bit (mask 0x80007FFF) and writing 0 leaves it unchanged. Bits outside 0x80007FFF always read 0.
- R5: A high evt_i bit sets the matching implemented status bit at the next clock edge, even while the bank is locked. An evt_i bit outside 0x80007FFF has no effect. A set status bit is cleared only by a write-1 or by reset.
- R6: When an event and a write-1-to-clear reach the same status bit in the same cycle, the bit ends up set.
- R7: A write to the mask register at offset 0x08 has no effect.
- R8: Writing 1s to offset 0x0C clears the matching mask bits. Writing 1s to offset 0x10 sets the matching implemented mask bits. Both offsets read 0.
- R9: irq_o is 1 exactly when some status bit is 1 and its mask bit is 0. It follows each status, enable, disable or event update in the cycle after the clock edge that made the update.
- R10: A read of any offset other than 0x00 to 0x10 returns 0. A read of offset 0x00 returns the lock bit in bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| reg_wr | input | 1 | Write strobe for one word |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| evt_i | input | 32 | Event pulses, one per status bit position |
| irq_o | output | 1 | Level interrupt |

## Verification
Every write and every event pulse takes effect at the first rising edge on which it is present. The new register values and the new irq_o level are visible right after that edge, because reads and the interrupt are combinational from the registers.

The bench drives all inputs at falling edges. It samples read data and irq_o shortly after the falling edge that follows the update edge, so each result is taken exactly one edge after its stimulus. The set-versus-clear case drives the event and the clearing write in the same half cycle, so both reach the same rising edge.

// File: rtl/irqbank_pkg.sv
package irqbank_pkg;
  localparam logic [7:0] OFS_LOCK = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_MASK = 8'h08;
  localparam logic [7:0] OFS_EN   = 8'h0C;
  localparam logic [7:0] OFS_DIS  = 8'h10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_LOCK,
    SEL_STAT,
    SEL_MASK,
    SEL_EN,
    SEL_DIS
  } reg_sel_e;
endpackage

// File: rtl/irqbank_decode.sv
module irqbank_decode
  import irqbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  always_comb begin
    sel_o = SEL_NONE;
    if (addr_i == ADDR_W'(OFS_LOCK)) sel_o = SEL_LOCK;
    else if (addr_i == ADDR_W'(OFS_STAT)) sel_o = SEL_STAT;
    else if (addr_i == ADDR_W'(OFS_MASK)) sel_o = SEL_MASK;
    else if (addr_i == ADDR_W'(OFS_EN)) sel_o = SEL_EN;
    else if (addr_i == ADDR_W'(OFS_DIS)) sel_o = SEL_DIS;
  end
endmodule

// File: rtl/irqbank_lock.sv
module irqbank_lock #(
  parameter int unsigned        DATA_W   = 32,
  parameter logic [DATA_W-1:0]  PASSCODE = 32'h0000DF0D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              locked_o
);
  logic lock_q, lock_d, lock_en;

  always_comb begin
    lock_en = wr_i;
    lock_d  = (wdata_i != PASSCODE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b1;
    else if (lock_en) lock_q <= lock_d;
  end

  assign locked_o = lock_q;

  // R2: the lock only moves on a write to its own offset
  assert_lock_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(lock_q));
endmodule

// File: rtl/irqbank_status.sv
module irqbank_status #(
  parameter int unsigned       DATA_W    = 32,
  parameter logic [DATA_W-1:0] IMPL_MASK = 32'h80007FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] clr_i,
  output logic [DATA_W-1:0] status_o
);
  logic [DATA_W-1:0] stat_q, stat_d;
  logic              stat_en;
  logic [DATA_W-1:0] keep_w;
  logic [DATA_W-1:0] both_w;

  always_comb begin
    stat_en = (|set_i) | (|clr_i);
    stat_d  = ((stat_q & ~clr_i) | set_i) & IMPL_MASK;
    keep_w  = stat_q & ~clr_i;
    both_w  = set_i & clr_i & IMPL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  assign status_o = stat_q;

  // R5: bits that are not cleared by software stay set
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(keep_w)) == $past(keep_w)));

  // R6: a set and a clear on the same bit leave the bit set
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|both_w) |=> ((stat_q & $past(both_w)) == $past(both_w)));
endmodule

// File: rtl/irqbank_mask.sv
module irqbank_mask #(
  parameter int unsigned       DATA_W    = 32,
  parameter logic [DATA_W-1:0] IMPL_MASK = 32'h80007FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_wr_i,
  input  logic              dis_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] status_i,
  output logic [DATA_W-1:0] mask_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] mask_q, mask_d;
  logic              mask_en;

  always_comb begin
    mask_en = en_wr_i | dis_wr_i;
    mask_d  = mask_q;
    if (en_wr_i) mask_d = mask_q & ~wdata_i;
    else if (dis_wr_i) mask_d = mask_q | (wdata_i & IMPL_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= IMPL_MASK;
    else if (mask_en) mask_q <= mask_d;
  end

  assign mask_o = mask_q;
  assign irq_o  = |(status_i & ~mask_q);

  // R7: without an enable or disable write the mask holds
  assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_wr_i || dis_wr_i) |=> $stable(mask_q));
endmodule

// File: rtl/irq_lock_regbank.sv
module irq_lock_regbank
  import irqbank_pkg::*;
#(
  parameter int unsigned             ADDR_W    = 8,
  parameter int unsigned             DATA_W    = 32,
  parameter logic [DATA_W-1:0]       IMPL_MASK = 32'h80007FFF,
  parameter logic [DATA_W-1:0]       PASSCODE  = 32'h0000DF0D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] evt_i,
  output logic              irq_o
);
  reg_sel_e          sel;
  logic              locked;
  logic              wr_ok;
  logic              lock_wr;
  logic [DATA_W-1:0] clr_vec;
  logic [DATA_W-1:0] set_vec;
  logic [DATA_W-1:0] status;
  logic [DATA_W-1:0] mask;
  logic              en_wr, dis_wr;

  irqbank_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (reg_addr),
    .sel_o  (sel)
  );

  always_comb begin
    lock_wr = reg_wr && (sel == SEL_LOCK);
    wr_ok   = reg_wr && !locked;
    clr_vec = (wr_ok && sel == SEL_STAT) ? reg_wdata : '0;
    set_vec = evt_i & IMPL_MASK;
    en_wr   = wr_ok && (sel == SEL_EN);
    dis_wr  = wr_ok && (sel == SEL_DIS);
  end

  irqbank_lock #(.DATA_W(DATA_W), .PASSCODE(PASSCODE)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (lock_wr),
    .wdata_i  (reg_wdata),
    .locked_o (locked)
  );

  irqbank_status #(.DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (set_vec),
    .clr_i    (clr_vec),
    .status_o (status)
  );

  irqbank_mask #(.DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_wr_i  (en_wr),
    .dis_wr_i (dis_wr),
    .wdata_i  (reg_wdata),
    .status_i (status),
    .mask_o   (mask),
    .irq_o    (irq_o)
  );

  always_comb begin
    unique case (sel)
      SEL_LOCK: reg_rdata = {{(DATA_W-1){1'b0}}, locked};
      SEL_STAT: reg_rdata = status;
      SEL_MASK: reg_rdata = mask;
      default:  reg_rdata = '0;
    endcase
  end

  // R3: a locked enable or disable write leaves the mask untouched
  assert_locked_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && reg_wr && (sel == SEL_EN || sel == SEL_DIS)) |=> $stable(mask));
endmodule

// File: tb/irq_lock_regbank_tb_top.sv
`timescale 1ns/1ps
module irq_lock_regbank_tb_top;
  localparam logic [31:0] IMPL = 32'h80007FFF;
  localparam logic [7:0] A_LOCK = 8'h00, A_STAT = 8'h04, A_MASK = 8'h08,
                         A_EN = 8'h0C, A_DIS = 8'h10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] evt;
  logic [31:0] rdata;
  logic        irq;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  irq_lock_regbank dut_i (
    .clk (clk), .rst_n (rst_n), .reg_wr (wr), .reg_addr (addr),
    .reg_wdata (wdata), .reg_rdata (rdata), .evt_i (evt), .irq_o (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic pulse(input logic [31:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = '0;
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] stat_m;
    logic [31:0] mask_m;
    rst_n = 1'b0; wr = 1'b0; addr = '0; wdata = '0; evt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_reg(A_LOCK, v); chk("R1 lock", v, 32'h1);
    rd_reg(A_STAT, v); chk("R1 status", v, 32'h0);
    rd_reg(A_MASK, v); chk("R1 mask", v, IMPL);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R3 locked writes dropped; R5 events still land
    pulse(32'h1);
    rd_reg(A_STAT, v); chk("R5 event while locked", v, 32'h1);
    wr_reg(A_STAT, 32'h1);
    rd_reg(A_STAT, v); chk("R3 locked w1c dropped", v, 32'h1);
    wr_reg(A_EN, 32'hFFFFFFFF);
    rd_reg(A_MASK, v); chk("R3 locked enable dropped", v, IMPL);
    chk("R3 irq stays low", {31'b0, irq}, 32'h0);

    // R2 passcode handling
    wr_reg(A_LOCK, 32'h00001234); rd_reg(A_LOCK, v); chk("R2 wrong code", v, 32'h1);
    wr_reg(A_LOCK, 32'h0000DF0D); rd_reg(A_LOCK, v); chk("R2 unlock", v, 32'h0);
    wr_reg(A_LOCK, 32'h0001DF0D); rd_reg(A_LOCK, v); chk("R2 inexact relocks", v, 32'h1);
    wr_reg(A_LOCK, 32'h0000DF0D);
    wr_reg(A_STAT, 32'hFFFFFFFF);
    rd_reg(A_STAT, v); chk("R4 clear all", v, 32'h0);

    // sweep every bit position
    stat_m = '0; mask_m = IMPL;
    for (int i = 0; i < 32; i++) begin
      logic [31:0] b;
      b = 32'h1 << i;
      pulse(b); stat_m |= b & IMPL;
      rd_reg(A_STAT, v); chk("R5 event sets bit", v, stat_m);
      chk("R9 masked no irq", {31'b0, irq}, 32'h0);
      wr_reg(A_EN, b); mask_m &= ~b;
      rd_reg(A_MASK, v); chk("R8 enable clears", v, mask_m);
      chk("R9 irq after enable", {31'b0, irq}, {31'b0, |(stat_m & ~mask_m)});
      wr_reg(A_MASK, 32'h0);
      rd_reg(A_MASK, v); chk("R7 direct mask write", v, mask_m);
      rd_reg(A_EN, v); chk("R8 enable reads 0", v, 32'h0);
      rd_reg(A_DIS, v); chk("R8 disable reads 0", v, 32'h0);
      wr_reg(A_STAT, b); stat_m &= ~b;
      rd_reg(A_STAT, v); chk("R4 w1c", v, stat_m);
      chk("R9 irq after clear", {31'b0, irq}, 32'h0);
      wr_reg(A_DIS, b); mask_m |= b & IMPL;
      rd_reg(A_MASK, v); chk("R8 disable sets", v, mask_m);
    end

    // R4 reserved bits read 0, partial clear
    pulse(32'hFFFFFFFF);
    rd_reg(A_STAT, v); chk("R4 reserved zero", v, IMPL);
    wr_reg(A_STAT, 32'h000000FF);
    rd_reg(A_STAT, v); chk("R4 partial w1c", v, IMPL & ~32'hFF);
    wr_reg(A_STAT, 32'hFFFFFFFF);

    // R5 sticky across idle cycles and unrelated clears; R9 timing
    wr_reg(A_EN, 32'h8);
    pulse(32'h8);
    chk("R9 irq one edge after event", {31'b0, irq}, 32'h1);
    wr_reg(A_STAT, 32'h10);
    repeat (5) @(negedge clk);
    rd_reg(A_STAT, v); chk("R5 sticky", v, 32'h8);
    chk("R9 irq held", {31'b0, irq}, 32'h1);

    // R6 set beats clear in same cycle
    @(negedge clk); evt = 32'h4; wr = 1'b1; addr = A_STAT; wdata = 32'h4;
    @(negedge clk); evt = '0; wr = 1'b0;
    rd_reg(A_STAT, v); chk("R6 set wins", v, 32'hC);

    // R10 unmapped reads
    rd_reg(8'h14, v); chk("R10 unmapped 0x14", v, 32'h0);
    rd_reg(8'h40, v); chk("R10 unmapped 0x40", v, 32'h0);
    rd_reg(8'h05, v); chk("R10 unaligned", v, 32'h0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule